// File: doc/BRIEF.md
# Register File with Pointer Pairs

This block is the general-purpose register storage of a small 8-bit RISC core: 32 byte-wide registers with two combinational read ports that feed the two ALU operands and one write port that takes the ALU result. An operand read, the operation and the write-back of the result all fit in one clock cycle. The new value becomes visible on the read ports from the next cycle.

The six highest byte registers also act as three 16-bit address pointers. Pointer 0 is registers 26/27, pointer 1 is 28/29 and pointer 2 is 30/31, with the even register as the low byte and the odd one as the high byte. A pointer port reads any pair as one 16-bit word and writes a whole pair in one cycle, as needed for post-increment and pre-decrement addressing. Pointer 2 is also driven onto a dedicated output, so that a program-memory constant lookup can use it at any time.

The ALU, the decoder and the memories are outside this block. Only the storage and its ports are here.

Top module: `gpr_bank`

## Requirements
- R1: A synchronous reset (rst high at a rising clock edge) clears every register to zero. After it, both read ports, the pointer read port and the lookup output return zero.
- R2: With wr_en high at a rising edge, wr_data is stored into register wr_addr.
- R3: The two read ports are independent and combinational. Each returns the register at its own address in the same cycle the address is presented, and any register can be read in one cycle.
- R4: A read of the register being written in the same cycle returns its old value. The new value appears on the read ports in the next cycle.
- R5: Pointer select code 0 names registers 26 (low byte) and 27 (high byte), code 1 names 28/29 and code 2 names 30/31. ptr_rd_data is {odd register, even register} of the selected pair.
- R6: With ptr_wr_en high and a valid select code, ptr_wr_data[7:0] goes to the even register and ptr_wr_data[15:8] to the odd register of the pair, both at the same edge. The bytes are visible on the byte read ports afterwards.
- R7: When a pointer write and a byte write hit the same register in one cycle, the pointer byte wins. A byte write to any register outside that pair still lands in the same cycle.
- R8: lookup_ptr always equals {register 31, register 30}.
- R9: Select code 3 is invalid. A pointer write with it changes no register, and a pointer read with it returns zero.
- R10: A write changes only the register or registers it addresses, and all others keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_addr | input | 5 | Address of operand A |
| rd_a_data | output | 8 | Operand A value |
| rd_b_addr | input | 5 | Address of operand B |
| rd_b_data | output | 8 | Operand B value |
| wr_en | input | 1 | Byte write enable |
| wr_addr | input | 5 | Byte write address |
| wr_data | input | 8 | Byte write data (ALU result) |
| ptr_wr_en | input | 1 | Pointer write enable |
| ptr_wr_sel | input | 2 | Pointer write select (0, 1, 2 valid) |
| ptr_wr_data | input | 16 | Pointer write value |
| ptr_rd_sel | input | 2 | Pointer read select |
| ptr_rd_data | output | 16 | Pointer read value |
| lookup_ptr | output | 16 | Pair 30/31 as a 16-bit lookup address |

## Verification
The bench builds the block with its default parameters: 32 registers of 8 bits, three pointers starting at register 26, pointer 2 on the lookup output and the indexed read multiplexer. These values make the whole address space reachable, so every register is filled and read back. The same settings leave select code 3 unused, which lets the bench exercise the invalid pointer code. Collisions are driven on purpose: a read of the register being written, a pointer write landing on either byte that a byte write also targets, and a pointer write beside an unrelated byte write. A pointer increment that carries across the byte boundary is also driven.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

   // Index of the low byte of pointer pair 'sel' starting at register 'base'
   function automatic int pair_low_idx(input int base, input int sel);
      return base + 2 * sel;
   endfunction

   // Index of the high byte of pointer pair 'sel'
   function automatic int pair_high_idx(input int base, input int sel);
      return base + 2 * sel + 1;
   endfunction

   // Read multiplexer variants
   typedef enum int {
      RD_MUX_INDEXED = 0,
      RD_MUX_ONEHOT  = 1
   } rd_mux_kind_e;

endpackage

// File: rtl/gpr_write_ctrl.sv
module gpr_write_ctrl #(
   parameter int NUM_REGS = 32,
   parameter int DATA_W   = 8,
   parameter int NUM_PTRS = 3,
   parameter int PTR_BASE = 26,
   localparam int ADDR_W  = $clog2(NUM_REGS),
   localparam int PTR_W   = 2 * DATA_W,
   localparam int PSEL_W  = $clog2(NUM_PTRS + 1)
) (
   input  logic                             wr_en,
   input  logic [ADDR_W-1:0]                wr_addr,
   input  logic [DATA_W-1:0]                wr_data,
   input  logic                             ptr_wr_en,
   input  logic [PSEL_W-1:0]                ptr_wr_sel,
   input  logic [PTR_W-1:0]                 ptr_wr_data,
   output logic [NUM_REGS-1:0]              reg_we,
   output logic [NUM_REGS-1:0][DATA_W-1:0]  reg_d
);
   import gpr_pkg::*;

   logic ptr_valid;
   assign ptr_valid = ptr_wr_en && (int'(ptr_wr_sel) < NUM_PTRS);

   logic [NUM_PTRS-1:0] ptr_sel_hot;

   for (genvar p = 0; p < NUM_PTRS; p++) begin : g_psel
      assign ptr_sel_hot[p] = ptr_valid && (int'(ptr_wr_sel) == p);
   end

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      logic byte_hit;
      logic ptr_hit;
      logic [DATA_W-1:0] ptr_byte;

      assign byte_hit = wr_en && (wr_addr == ADDR_W'(i));

      if (i >= PTR_BASE && i < PTR_BASE + 2 * NUM_PTRS) begin : g_paired
         localparam int PIDX = (i - PTR_BASE) / 2;
         localparam bit IS_HIGH = ((i - PTR_BASE) % 2) == 1;
         assign ptr_hit = ptr_sel_hot[PIDX];
         if (IS_HIGH) begin : g_hi
            assign ptr_byte = ptr_wr_data[PTR_W-1:DATA_W];
         end else begin : g_lo
            assign ptr_byte = ptr_wr_data[DATA_W-1:0];
         end
      end else begin : g_plain
         assign ptr_hit  = 1'b0;
         assign ptr_byte = '0;
      end

      // pointer write has priority over a byte write to the same register
      assign reg_we[i] = ptr_hit | byte_hit;
      assign reg_d[i]  = ptr_hit ? ptr_byte : wr_data;
   end

   // at most one pointer pair can be selected in a cycle
   always_comb begin
      a_one_pair_r7: assert ($onehot0(ptr_sel_hot))
         else $error("more than one pointer pair selected");
   end

endmodule

// File: rtl/gpr_storage.sv
module gpr_storage #(
   parameter int NUM_REGS = 32,
   parameter int DATA_W   = 8
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic [NUM_REGS-1:0]              reg_we,
   input  logic [NUM_REGS-1:0][DATA_W-1:0]  reg_d,
   output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q
);

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_cell
      always_ff @(posedge clk) begin
         if (rst) begin
            regs_q[i] <= '0;
         end else if (reg_we[i]) begin
            regs_q[i] <= reg_d[i];
         end
      end

      // a register with no write enable holds its value (R10)
      p_hold_r10: assert property (@(posedge clk) disable iff (rst)
         !reg_we[i] |=> $stable(regs_q[i]))
         else $error("register %0d changed without a write", i);
   end

endmodule

// File: rtl/gpr_read_mux.sv
module gpr_read_mux #(
   parameter int NUM_REGS = 32,
   parameter int DATA_W   = 8,
   parameter int MUX_KIND = 0,
   localparam int ADDR_W  = $clog2(NUM_REGS)
) (
   input  logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q,
   input  logic [ADDR_W-1:0]                addr,
   output logic [DATA_W-1:0]                data
);
   import gpr_pkg::*;

   if (MUX_KIND == RD_MUX_ONEHOT) begin : g_onehot
      logic [NUM_REGS-1:0] hot;
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
         assign hot[i] = (addr == ADDR_W'(i));
      end
      always_comb begin
         data = '0;
         for (int i = 0; i < NUM_REGS; i++) begin
            data = data | (regs_q[i] & {DATA_W{hot[i]}});
         end
      end
      always_comb begin
         a_onehot_dec_r3: assert ($onehot(hot))
            else $error("read decode not one-hot");
      end
   end else begin : g_indexed
      assign data = regs_q[addr];
   end

endmodule

// File: rtl/gpr_ptr_view.sv
module gpr_ptr_view #(
   parameter int NUM_REGS   = 32,
   parameter int DATA_W     = 8,
   parameter int NUM_PTRS   = 3,
   parameter int PTR_BASE   = 26,
   parameter int LOOKUP_SEL = 2,
   localparam int PTR_W     = 2 * DATA_W,
   localparam int PSEL_W    = $clog2(NUM_PTRS + 1)
) (
   input  logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q,
   input  logic [PSEL_W-1:0]                ptr_rd_sel,
   output logic [PTR_W-1:0]                 ptr_rd_data,
   output logic [PTR_W-1:0]                 lookup_ptr
);
   import gpr_pkg::*;

   logic [NUM_PTRS-1:0][PTR_W-1:0] pair_val;

   for (genvar p = 0; p < NUM_PTRS; p++) begin : g_pair
      localparam int LO = pair_low_idx(PTR_BASE, p);
      localparam int HI = pair_high_idx(PTR_BASE, p);
      assign pair_val[p] = {regs_q[HI], regs_q[LO]};
   end

   always_comb begin
      ptr_rd_data = '0;
      for (int p = 0; p < NUM_PTRS; p++) begin
         if (int'(ptr_rd_sel) == p) begin
            ptr_rd_data = pair_val[p];
         end
      end
   end

   assign lookup_ptr = pair_val[LOOKUP_SEL];

endmodule

// File: rtl/gpr_bank.sv
module gpr_bank #(
   parameter int NUM_REGS   = 32,
   parameter int DATA_W     = 8,
   parameter int NUM_PTRS   = 3,
   parameter int PTR_BASE   = 26,
   parameter int LOOKUP_SEL = 2,
   parameter int MUX_KIND   = 0,
   localparam int ADDR_W    = $clog2(NUM_REGS),
   localparam int PTR_W     = 2 * DATA_W,
   localparam int PSEL_W    = $clog2(NUM_PTRS + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] rd_a_addr,
   output logic [DATA_W-1:0] rd_a_data,
   input  logic [ADDR_W-1:0] rd_b_addr,
   output logic [DATA_W-1:0] rd_b_data,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              ptr_wr_en,
   input  logic [PSEL_W-1:0] ptr_wr_sel,
   input  logic [PTR_W-1:0]  ptr_wr_data,
   input  logic [PSEL_W-1:0] ptr_rd_sel,
   output logic [PTR_W-1:0]  ptr_rd_data,
   output logic [PTR_W-1:0]  lookup_ptr
);
   import gpr_pkg::*;

   localparam int LOOKUP_HI = pair_high_idx(PTR_BASE, LOOKUP_SEL);

   // elaboration-time parameter checks
   if (NUM_REGS != (1 << ADDR_W)) begin : g_chk_pow2
      $error("NUM_REGS must be a power of two");
   end
   if ((PTR_BASE % 2) != 0) begin : g_chk_even
      $error("PTR_BASE must be even");
   end
   if (PTR_BASE + 2 * NUM_PTRS > NUM_REGS) begin : g_chk_fit
      $error("pointer pairs exceed register count");
   end
   if (LOOKUP_SEL >= NUM_PTRS) begin : g_chk_lookup
      $error("LOOKUP_SEL out of range");
   end
   if (MUX_KIND != RD_MUX_INDEXED && MUX_KIND != RD_MUX_ONEHOT) begin : g_chk_mux
      $error("unknown MUX_KIND");
   end

   logic [NUM_REGS-1:0]             reg_we;
   logic [NUM_REGS-1:0][DATA_W-1:0] reg_d;
   logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

   gpr_write_ctrl #(
      .NUM_REGS (NUM_REGS),
      .DATA_W   (DATA_W),
      .NUM_PTRS (NUM_PTRS),
      .PTR_BASE (PTR_BASE)
   ) u_wctl (
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .ptr_wr_en   (ptr_wr_en),
      .ptr_wr_sel  (ptr_wr_sel),
      .ptr_wr_data (ptr_wr_data),
      .reg_we      (reg_we),
      .reg_d       (reg_d)
   );

   gpr_storage #(
      .NUM_REGS (NUM_REGS),
      .DATA_W   (DATA_W)
   ) u_store (
      .clk    (clk),
      .rst    (rst),
      .reg_we (reg_we),
      .reg_d  (reg_d),
      .regs_q (regs_q)
   );

   gpr_read_mux #(
      .NUM_REGS (NUM_REGS),
      .DATA_W   (DATA_W),
      .MUX_KIND (MUX_KIND)
   ) u_rd_a (
      .regs_q (regs_q),
      .addr   (rd_a_addr),
      .data   (rd_a_data)
   );

   gpr_read_mux #(
      .NUM_REGS (NUM_REGS),
      .DATA_W   (DATA_W),
      .MUX_KIND (MUX_KIND)
   ) u_rd_b (
      .regs_q (regs_q),
      .addr   (rd_b_addr),
      .data   (rd_b_data)
   );

   gpr_ptr_view #(
      .NUM_REGS   (NUM_REGS),
      .DATA_W     (DATA_W),
      .NUM_PTRS   (NUM_PTRS),
      .PTR_BASE   (PTR_BASE),
      .LOOKUP_SEL (LOOKUP_SEL)
   ) u_pview (
      .regs_q      (regs_q),
      .ptr_rd_sel  (ptr_rd_sel),
      .ptr_rd_data (ptr_rd_data),
      .lookup_ptr  (lookup_ptr)
   );

   // ---------------- assertions ----------------
   logic              ptr_ok;
   logic [ADDR_W-1:0] ptr_lo_addr;
   logic [ADDR_W-1:0] ptr_hi_addr;
   logic              byte_in_pair;

   assign ptr_ok       = ptr_wr_en && (int'(ptr_wr_sel) < NUM_PTRS);
   assign ptr_lo_addr  = ADDR_W'(PTR_BASE + 2 * int'(ptr_wr_sel));
   assign ptr_hi_addr  = ADDR_W'(PTR_BASE + 2 * int'(ptr_wr_sel) + 1);
   assign byte_in_pair = ptr_ok && (wr_addr == ptr_lo_addr || wr_addr == ptr_hi_addr);

   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (regs_q == '0))
      else $error("registers not cleared by reset");

   p_wr_lands_r2: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !byte_in_pair) |=> (regs_q[$past(wr_addr)] == $past(wr_data)))
      else $error("byte write lost");

   p_ptr_pair_r6: assert property (@(posedge clk) disable iff (rst)
      ptr_ok |=> ({regs_q[$past(ptr_hi_addr)], regs_q[$past(ptr_lo_addr)]} == $past(ptr_wr_data)))
      else $error("pointer write did not update both bytes");

   p_ptr_prio_r7: assert property (@(posedge clk) disable iff (rst)
      (byte_in_pair && wr_addr == ptr_lo_addr) |=> (regs_q[$past(wr_addr)] == $past(ptr_wr_data[DATA_W-1:0])))
      else $error("byte write overrode pointer low byte");

   p_lookup_r8: assert property (@(posedge clk) disable iff (rst)
      (rd_b_addr == ADDR_W'(LOOKUP_HI)) |-> (rd_b_data == lookup_ptr[PTR_W-1:DATA_W]))
      else $error("lookup output disagrees with read port");

   p_bad_sel_r9: assert property (@(posedge clk) disable iff (rst)
      (ptr_wr_en && !ptr_ok && !wr_en) |=> $stable(regs_q))
      else $error("invalid pointer select changed state");

endmodule

// File: tb/gpr_bank_tb_top.sv
`timescale 1ns/1ps
module gpr_bank_tb_top;
   logic        clk = 1'b0;
   logic        rst;
   logic [4:0]  rd_a_addr, rd_b_addr, wr_addr;
   logic [7:0]  rd_a_data, rd_b_data, wr_data;
   logic        wr_en, ptr_wr_en;
   logic [1:0]  ptr_wr_sel, ptr_rd_sel;
   logic [15:0] ptr_wr_data, ptr_rd_data, lookup_ptr;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   logic [7:0] mdl [32];

   always #2.5 clk = ~clk;

   gpr_bank dut_i (
      .clk(clk), .rst(rst),
      .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
      .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .ptr_wr_en(ptr_wr_en), .ptr_wr_sel(ptr_wr_sel), .ptr_wr_data(ptr_wr_data),
      .ptr_rd_sel(ptr_rd_sel), .ptr_rd_data(ptr_rd_data),
      .lookup_ptr(lookup_ptr)
   );

   task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // read register idx on both ports (called at a negedge context)
   task automatic chk_reg(input int idx, input string tag);
      rd_a_addr = 5'(idx);
      rd_b_addr = 5'(idx);
      #1;
      chk(rd_a_data == mdl[idx], tag, {8'h0, rd_a_data}, {8'h0, mdl[idx]});
      chk(rd_b_data == mdl[idx], tag, {8'h0, rd_b_data}, {8'h0, mdl[idx]});
   endtask

   task automatic chk_all(input string tag);
      for (int i = 0; i < 32; i++) chk_reg(i, tag);
   endtask

   // one clock with optional byte and pointer writes; updates the model
   task automatic do_cycle(input bit we, input int addr, input logic [7:0] d,
                           input bit pe, input int sel, input logic [15:0] pd);
      @(negedge clk);
      wr_en = we; wr_addr = 5'(addr); wr_data = d;
      ptr_wr_en = pe; ptr_wr_sel = 2'(sel); ptr_wr_data = pd;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; ptr_wr_en = 1'b0;
      if (we) mdl[addr] = d;
      if (pe && sel < 3) begin
         mdl[26 + 2 * sel] = pd[7:0];
         mdl[27 + 2 * sel] = pd[15:8];
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
   endtask

   task automatic t_reset_r1();
      do_reset();
      chk_all("R1 register after reset");
      for (int s = 0; s < 3; s++) begin
         ptr_rd_sel = 2'(s);
         #1;
         chk(ptr_rd_data == 16'h0, "R1 pointer after reset", ptr_rd_data, 16'h0);
      end
      chk(lookup_ptr == 16'h0, "R1 lookup after reset", lookup_ptr, 16'h0);
   endtask

   task automatic t_fill_r2_r3();
      for (int i = 0; i < 32; i++) do_cycle(1'b1, i, 8'((i * 37 + 11) & 8'hFF), 1'b0, 0, 16'h0);
      chk_all("R2 filled register");
      for (int i = 0; i < 32; i++) begin
         rd_a_addr = 5'(i);
         rd_b_addr = 5'((i + 13) % 32);
         #1;
         chk(rd_a_data == mdl[i], "R3 port A independent", {8'h0, rd_a_data}, {8'h0, mdl[i]});
         chk(rd_b_data == mdl[(i + 13) % 32], "R3 port B independent",
             {8'h0, rd_b_data}, {8'h0, mdl[(i + 13) % 32]});
      end
   endtask

   task automatic t_collide_r4_r10();
      logic [7:0] old;
      @(negedge clk);
      old = mdl[9];
      wr_en = 1'b1; wr_addr = 5'd9; wr_data = 8'hA5;
      rd_a_addr = 5'd9;
      #1;
      chk(rd_a_data == old, "R4 old value during write", {8'h0, rd_a_data}, {8'h0, old});
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
      mdl[9] = 8'hA5;
      #1;
      chk(rd_a_data == 8'hA5, "R4 new value next cycle", {8'h0, rd_a_data}, 16'h00A5);
      chk_all("R10 other registers untouched");
   endtask

   task automatic t_ptr_read_r5();
      do_cycle(1'b1, 26, 8'h3C, 1'b0, 0, 16'h0);
      do_cycle(1'b1, 31, 8'hC3, 1'b0, 0, 16'h0);
      for (int s = 0; s < 3; s++) begin
         ptr_rd_sel = 2'(s);
         #1;
         chk(ptr_rd_data == {mdl[27 + 2 * s], mdl[26 + 2 * s]}, "R5 pointer read pair",
             ptr_rd_data, {mdl[27 + 2 * s], mdl[26 + 2 * s]});
      end
   endtask

   task automatic t_ptr_write_r6_r8();
      logic [15:0] z;
      do_cycle(1'b0, 0, 8'h0, 1'b1, 0, 16'h1234);
      do_cycle(1'b0, 0, 8'h0, 1'b1, 1, 16'hBEEF);
      do_cycle(1'b0, 0, 8'h0, 1'b1, 2, 16'h00FF);
      for (int i = 26; i < 32; i++) chk_reg(i, "R6 pointer bytes on byte port");
      chk_reg(25, "R10 register below pairs untouched");
      chk(lookup_ptr == 16'h00FF, "R8 lookup after pointer write", lookup_ptr, 16'h00FF);
      // post-increment across the byte boundary
      ptr_rd_sel = 2'd2;
      #1;
      z = ptr_rd_data + 16'h1;
      do_cycle(1'b0, 0, 8'h0, 1'b1, 2, z);
      chk(lookup_ptr == 16'h0100, "R8 lookup after increment", lookup_ptr, 16'h0100);
      chk_reg(30, "R6 low byte after increment");
      chk_reg(31, "R6 high byte after increment");
      ptr_rd_sel = 2'd1;
      #1;
      chk(ptr_rd_data == 16'hBEEF, "R6 pointer read after write", ptr_rd_data, 16'hBEEF);
      // byte write into pair 30/31 is seen on the lookup output
      do_cycle(1'b1, 30, 8'h77, 1'b0, 0, 16'h0);
      chk(lookup_ptr == 16'h0177, "R8 lookup tracks byte write", lookup_ptr, 16'h0177);
   endtask

   task automatic t_prio_r7();
      // byte write to high byte of pair 1 collides with pointer write
      do_cycle(1'b1, 29, 8'h11, 1'b1, 1, 16'h5A6B);
      chk_reg(29, "R7 pointer wins high byte");
      chk_reg(28, "R7 pointer low byte");
      // byte write to low byte collides
      do_cycle(1'b1, 30, 8'h22, 1'b1, 2, 16'h9876);
      chk_reg(30, "R7 pointer wins low byte");
      chk_reg(31, "R7 pointer high byte");
      // unrelated byte write lands alongside pointer write
      do_cycle(1'b1, 4, 8'h44, 1'b1, 0, 16'h7788);
      chk_reg(4, "R7 unrelated byte write lands");
      chk_reg(26, "R7 pointer with unrelated write low");
      chk_reg(27, "R7 pointer with unrelated write high");
   endtask

   task automatic t_bad_sel_r9();
      do_cycle(1'b0, 0, 8'h0, 1'b1, 3, 16'hFFFF);
      chk_all("R9 invalid pointer write ignored");
      ptr_rd_sel = 2'd3;
      #1;
      chk(ptr_rd_data == 16'h0, "R9 invalid pointer read is zero", ptr_rd_data, 16'h0);
      chk(lookup_ptr == {mdl[31], mdl[30]}, "R8 lookup unchanged", lookup_ptr, {mdl[31], mdl[30]});
   endtask

   initial begin
      rst = 1'b1;
      wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      ptr_wr_en = 1'b0; ptr_wr_sel = '0; ptr_wr_data = '0;
      ptr_rd_sel = '0; rd_a_addr = '0; rd_b_addr = '0;
      repeat (3) @(negedge clk);
      t_reset_r1();
      t_fill_r2_r3();
      t_collide_r4_r10();
      t_ptr_read_r5();
      t_ptr_write_r6_r8();
      t_prio_r7();
      t_bad_sel_r9();
      t_reset_r1();
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #1000000;
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule